// File: doc/BRIEF.md
# Powered-Device Startup Sequencer

This block is the digital sequencer for the power front end of an Ethernet-powered device. Its inputs are comparator decisions: the input rail rising above the turn-on level, the input rail collapsing below the turn-off level, a wall-adapter request, two pair-sense bits and two over-temperature alarms. It also receives the number of classification events counted upstream. From these it drives the series pass-FET enable, an inrush indication, power-good, the auxiliary-rail enable, a discharge window for the converter's input capacitor and the enable for the classification circuit.

When power arrives, the sequencer decodes four capability flags from the event count and the pair-sense bits. The flags are type-2, HDBaseT, 4-pair type-2 and 4-pair HDBaseT, and each is an active-high bit standing in for an open-drain pull-down. The flags are frozen when power arrives. Flags, power-good and the auxiliary rail are released only after a fixed inrush interval counted in milliseconds. The millisecond time base is either an external tick or an internal prescaler, selected by a parameter. A wall adapter overrides everything: the pass FET opens, every flag reports active and the auxiliary rail comes up.

Top module: `pd_startup_seq`

## Requirements
- R1: After reset with no alarms and no adapter, every output is low except `cls_en_o`, which is high.
- R2: Flag bits are [0] type-2, [1] HDBaseT, [2] 4-pair type-2, [3] 4-pair HDBaseT. Two events give bit 0, plus bit 2 when both sense bits are 1. Three events give bits 0 and 1, plus bit 2 when both sense bits are 1. Four events give bits 0 to 2 for any sense value. Six events give all four bits.
- R3: An event count of 0, 1, 5 or 7 or more gives no flag bits.
- R4: Flags are taken from the count and sense inputs in the cycle the sequencer leaves idle. Later changes to those inputs do not alter `flags_o`.
- R5: From idle, `uvlo_on_i` high (with `uvlo_off_i`, `wa_en_i` and `fet_ot_i` low) raises `fet_en_o` and `inrush_o` on the next edge. `pgood_o`, `aux_en_o` and the flags appear on the edge that takes the INRUSH_MS-th millisecond tick.
- R6: `uvlo_off_i` while the FET is on clears `fet_en_o`, `pgood_o`, `aux_en_o` and `flags_o` on the next edge. `disch_o` is then high for exactly DISCH_MS ticks, after which a new start is possible.
- R7: While `wa_en_i` is high, `fet_en_o`, `pgood_o` and `cls_en_o` are low, `aux_en_o` is high and `flags_o` is 4'b1111. No start occurs. If the adapter arrives while powered, the sequencer returns to idle without a discharge.
- R8: `fet_ot_i` forces `fet_en_o` low in the same cycle. While powered it starts the discharge window, and in idle it blocks a start.
- R9: `cls_ot_i` forces `cls_en_o` low.
- R10: During the discharge window, `uvlo_on_i` is ignored and the FET stays off.
- R11: With the internal prescaler, one millisecond is CLK_PER_MS clocks and `ms_tick_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick_i | input | 1 | External millisecond strobe (used when USE_EXT_TICK=1) |
| uvlo_on_i | input | 1 | Input rail above turn-on threshold |
| uvlo_off_i | input | 1 | Input rail below turn-off threshold |
| wa_en_i | input | 1 | Wall-adapter priority request |
| pair_sense_i | input | 2 | Spare-pair presence bits |
| fet_ot_i | input | 1 | Pass-FET over-temperature |
| cls_ot_i | input | 1 | Class-sink over-temperature |
| class_evt_cnt_i | input | CNT_W | Classification events counted upstream |
| fet_en_o | output | 1 | Pass-FET enable |
| inrush_o | output | 1 | Inrush interval in progress |
| pgood_o | output | 1 | Power good |
| aux_en_o | output | 1 | Auxiliary rail enable |
| disch_o | output | 1 | Input-capacitor discharge active |
| cls_en_o | output | 1 | Classification circuit enable |
| flags_o | output | 4 | Capability flags, active high |

## Verification
The hardest case to reach is the freeze of the flags. The count and sense inputs must change after the capture edge but before power-good. The bench therefore reprograms them in the middle of the inrush interval and again after power-good, using the external tick so that the inrush interval can be held open for as long as needed. It then sweeps every count and sense combination through a full power-up and collapse. Discharge-window ignoring and the over-temperature paths are each entered from a known powered state.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
   localparam int NUM_FLAGS = 4;
   localparam int FLG_T2    = 0;
   localparam int FLG_HD    = 1;
   localparam int FLG_4PT2  = 2;
   localparam int FLG_4PHD  = 3;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_INRUSH  = 2'd1,
      ST_POWERED = 2'd2,
      ST_DISCH   = 2'd3
   } seq_state_e;
endpackage

// File: rtl/pd_ms_tick.sv
module pd_ms_tick #(
   parameter bit USE_EXT_TICK = 1'b0,
   parameter int CLK_PER_MS   = 100000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ms_tick_i,
   output logic tick_o
);
   generate
      if (USE_EXT_TICK) begin : g_ext
         assign tick_o = ms_tick_i;
      end else begin : g_pre
         localparam int PW = $clog2(CLK_PER_MS);
         localparam logic [PW-1:0] LAST = PW'(CLK_PER_MS - 1);
         logic [PW-1:0] div_q;
         logic          unused_ext_tick;

         assign unused_ext_tick = ms_tick_i;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             div_q <= '0;
            else if (div_q == LAST) div_q <= '0;
            else                    div_q <= div_q + 1'b1;
         end
         assign tick_o = (div_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/pd_flag_decode.sv
module pd_flag_decode
   import pd_seq_pkg::*;
#(
   parameter int CNT_W = 3
) (
   input  logic [CNT_W-1:0]     evt_cnt_i,
   input  logic [1:0]           sense_i,
   output logic [NUM_FLAGS-1:0] flags_o
);
   logic both_pairs;
   assign both_pairs = &sense_i;

   always_comb begin
      flags_o = '0;
      if (evt_cnt_i == CNT_W'(2)) begin
         flags_o[FLG_T2]   = 1'b1;
         flags_o[FLG_4PT2] = both_pairs;
      end else if (evt_cnt_i == CNT_W'(3)) begin
         flags_o[FLG_T2]   = 1'b1;
         flags_o[FLG_HD]   = 1'b1;
         flags_o[FLG_4PT2] = both_pairs;
      end else if (evt_cnt_i == CNT_W'(4)) begin
         flags_o[FLG_T2]   = 1'b1;
         flags_o[FLG_HD]   = 1'b1;
         flags_o[FLG_4PT2] = 1'b1;
      end else if (evt_cnt_i == CNT_W'(6)) begin
         flags_o = '1;
      end
   end
endmodule

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm
   import pd_seq_pkg::*;
#(
   parameter int INRUSH_MS = 80,
   parameter int DISCH_MS  = 430
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_i,
   input  logic                 uvlo_on_i,
   input  logic                 uvlo_off_i,
   input  logic                 wa_en_i,
   input  logic                 fet_ot_i,
   input  logic [NUM_FLAGS-1:0] dec_flags_i,
   output seq_state_e           state_o,
   output logic [NUM_FLAGS-1:0] flag_q_o
);
   localparam int TMAX  = (INRUSH_MS > DISCH_MS) ? INRUSH_MS : DISCH_MS;
   localparam int TW    = $clog2(TMAX + 1);
   localparam logic [TW-1:0] INR_LAST = TW'(INRUSH_MS - 1);
   localparam logic [TW-1:0] DIS_LAST = TW'(DISCH_MS - 1);

   seq_state_e           st_q;
   logic [TW-1:0]        ms_q;
   logic [NUM_FLAGS-1:0] flag_q;
   logic                 shutdown;

   assign shutdown = uvlo_off_i | fet_ot_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         ms_q   <= '0;
         flag_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (uvlo_on_i && !uvlo_off_i && !wa_en_i && !fet_ot_i) begin
                  st_q   <= ST_INRUSH;
                  ms_q   <= '0;
                  flag_q <= dec_flags_i;
               end
            end
            ST_INRUSH, ST_POWERED: begin
               if (shutdown) begin
                  st_q   <= ST_DISCH;
                  ms_q   <= '0;
                  flag_q <= '0;
               end else if (wa_en_i) begin
                  st_q   <= ST_IDLE;
                  flag_q <= '0;
               end else if (st_q == ST_INRUSH && tick_i) begin
                  if (ms_q == INR_LAST) begin
                     st_q <= ST_POWERED;
                     ms_q <= '0;
                  end else begin
                     ms_q <= ms_q + 1'b1;
                  end
               end
            end
            default: begin
               if (tick_i) begin
                  if (ms_q == DIS_LAST) begin
                     st_q <= ST_IDLE;
                     ms_q <= '0;
                  end else begin
                     ms_q <= ms_q + 1'b1;
                  end
               end
            end
         endcase
      end
   end

   assign state_o  = st_q;
   assign flag_q_o = flag_q;
endmodule

// File: rtl/pd_startup_seq.sv
module pd_startup_seq
   import pd_seq_pkg::*;
#(
   parameter int CNT_W        = 3,
   parameter bit USE_EXT_TICK = 1'b0,
   parameter int CLK_PER_MS   = 100000,
   parameter int INRUSH_MS    = 80,
   parameter int DISCH_MS     = 430
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ms_tick_i,
   input  logic             uvlo_on_i,
   input  logic             uvlo_off_i,
   input  logic             wa_en_i,
   input  logic [1:0]       pair_sense_i,
   input  logic             fet_ot_i,
   input  logic             cls_ot_i,
   input  logic [CNT_W-1:0] class_evt_cnt_i,
   output logic             fet_en_o,
   output logic             inrush_o,
   output logic             pgood_o,
   output logic             aux_en_o,
   output logic             disch_o,
   output logic             cls_en_o,
   output logic [3:0]       flags_o
);
   generate
      if (CNT_W < 3) begin : g_bad_cnt
         $error("CNT_W must hold a count of six");
      end
      if (INRUSH_MS < 1 || DISCH_MS < 1) begin : g_bad_time
         $error("timer lengths must be at least one millisecond");
      end
      if (!USE_EXT_TICK && CLK_PER_MS < 2) begin : g_bad_div
         $error("CLK_PER_MS must be at least 2");
      end
   endgenerate

   logic                 tick;
   logic [NUM_FLAGS-1:0] dec_flags;
   logic [NUM_FLAGS-1:0] flag_q;
   seq_state_e           st;
   logic                 running;
   logic                 powered;

   pd_ms_tick #(
      .USE_EXT_TICK(USE_EXT_TICK),
      .CLK_PER_MS  (CLK_PER_MS)
   ) tick_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ms_tick_i(ms_tick_i),
      .tick_o   (tick)
   );

   pd_flag_decode #(
      .CNT_W(CNT_W)
   ) dec_i (
      .evt_cnt_i(class_evt_cnt_i),
      .sense_i  (pair_sense_i),
      .flags_o  (dec_flags)
   );

   pd_seq_fsm #(
      .INRUSH_MS(INRUSH_MS),
      .DISCH_MS (DISCH_MS)
   ) fsm_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick),
      .uvlo_on_i  (uvlo_on_i),
      .uvlo_off_i (uvlo_off_i),
      .wa_en_i    (wa_en_i),
      .fet_ot_i   (fet_ot_i),
      .dec_flags_i(dec_flags),
      .state_o    (st),
      .flag_q_o   (flag_q)
   );

   assign running  = (st == ST_INRUSH || st == ST_POWERED) && !wa_en_i && !fet_ot_i;
   assign powered  = running && (st == ST_POWERED);

   assign fet_en_o = running;
   assign inrush_o = running && (st == ST_INRUSH);
   assign pgood_o  = powered;
   assign aux_en_o = wa_en_i | powered;
   assign disch_o  = (st == ST_DISCH);
   assign cls_en_o = (st == ST_IDLE) && !wa_en_i && !cls_ot_i;
   assign flags_o  = wa_en_i ? '1 : (powered ? flag_q : '0);
endmodule

// File: rtl/pd_startup_seq_chk.sv
module pd_startup_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       uvlo_on_i,
   input logic       uvlo_off_i,
   input logic       wa_en_i,
   input logic       fet_ot_i,
   input logic       cls_ot_i,
   input logic       fet_en_o,
   input logic       inrush_o,
   input logic       pgood_o,
   input logic       aux_en_o,
   input logic       disch_o,
   input logic       cls_en_o,
   input logic [3:0] flags_o
);
   // R7
   adapter_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wa_en_i |-> (!fet_en_o && !pgood_o && !cls_en_o && aux_en_o && flags_o == 4'hF));

   // R8
   fet_hot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fet_ot_i |-> !fet_en_o);

   // R9
   cls_hot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cls_ot_i |-> !cls_en_o);

   // R6
   collapse_disch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fet_en_o && uvlo_off_i) |=> (disch_o && !fet_en_o && !pgood_o && flags_o == 4'h0));

   // R5
   pgood_after_inrush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pgood_o) && !$past(wa_en_i)) |-> $past(inrush_o));

   // R4
   flags_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pgood_o && $past(pgood_o) && !wa_en_i && !$past(wa_en_i)) |-> $stable(flags_o));

   // R10
   disch_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disch_o && uvlo_on_i) |=> !fet_en_o);
endmodule

bind pd_startup_seq pd_startup_seq_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .uvlo_on_i (uvlo_on_i),
   .uvlo_off_i(uvlo_off_i),
   .wa_en_i   (wa_en_i),
   .fet_ot_i  (fet_ot_i),
   .cls_ot_i  (cls_ot_i),
   .fet_en_o  (fet_en_o),
   .inrush_o  (inrush_o),
   .pgood_o   (pgood_o),
   .aux_en_o  (aux_en_o),
   .disch_o   (disch_o),
   .cls_en_o  (cls_en_o),
   .flags_o   (flags_o)
);

// File: tb/pd_startup_seq_tb.sv
module pd_startup_seq_tb_top;
   localparam int INR = 4;
   localparam int DIS = 6;
   localparam int P_CPM = 4;
   localparam int P_INR = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ms_tick = 1'b0, uvlo_on = 1'b0, uvlo_off = 1'b0, wa = 1'b0;
   logic fot = 1'b0, cot = 1'b0;
   logic [1:0] sense = 2'b00;
   logic [2:0] evt = 3'd0;

   logic fet, inr, pg, aux, dis, cen;
   logic [3:0] flg;
   logic p_fet, p_inr, p_pg, p_aux, p_dis, p_cen;
   logic [3:0] p_flg;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pd_startup_seq #(.CNT_W(3), .USE_EXT_TICK(1'b1), .CLK_PER_MS(4),
                    .INRUSH_MS(INR), .DISCH_MS(DIS)) dut_i (
      .clk(clk), .rst_n(rst_n), .ms_tick_i(ms_tick), .uvlo_on_i(uvlo_on),
      .uvlo_off_i(uvlo_off), .wa_en_i(wa), .pair_sense_i(sense),
      .fet_ot_i(fot), .cls_ot_i(cot), .class_evt_cnt_i(evt),
      .fet_en_o(fet), .inrush_o(inr), .pgood_o(pg), .aux_en_o(aux),
      .disch_o(dis), .cls_en_o(cen), .flags_o(flg));

   pd_startup_seq #(.CNT_W(3), .USE_EXT_TICK(1'b0), .CLK_PER_MS(P_CPM),
                    .INRUSH_MS(P_INR), .DISCH_MS(2)) dut_pre_i (
      .clk(clk), .rst_n(rst_n), .ms_tick_i(1'b1), .uvlo_on_i(uvlo_on),
      .uvlo_off_i(uvlo_off), .wa_en_i(wa), .pair_sense_i(sense),
      .fet_ot_i(fot), .cls_ot_i(cot), .class_evt_cnt_i(evt),
      .fet_en_o(p_fet), .inrush_o(p_inr), .pgood_o(p_pg), .aux_en_o(p_aux),
      .disch_o(p_dis), .cls_en_o(p_cen), .flags_o(p_flg));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) ms_tick = 1'b1;
         @(negedge clk) ms_tick = 1'b0;
      end
   endtask

   task automatic power_up(input logic [2:0] c, input logic [1:0] s);
      @(negedge clk);
      evt = c; sense = s; uvlo_on = 1'b1;
      @(negedge clk);
   endtask

   task automatic power_down();
      @(negedge clk);
      uvlo_on = 1'b0; uvlo_off = 1'b1;
      @(negedge clk);
      uvlo_off = 1'b0;
      ticks(DIS);
   endtask

   function automatic logic [3:0] exp_flags(input int c, input int s);
      logic [3:0] f;
      f[0] = (c >= 2 && c <= 4) || c == 6;
      f[1] = (c == 3 || c == 4 || c == 6);
      f[2] = (c == 4 || c == 6) || ((c == 2 || c == 3) && s == 3);
      f[3] = (c == 6);
      return f;
   endfunction

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 outputs", {fet, inr, pg, aux, dis, flg}, 9'h0);
      chk("R1 cls_en", cen, 1'b1);

      // R2 / R3 sweep over every count and sense pattern
      for (int c = 0; c < 8; c++) begin
         for (int s = 0; s < 4; s++) begin
            power_up(3'(c), 2'(s));
            chk("R5 fet on at start", {fet, inr}, 2'b11);
            ticks(INR - 1);
            chk("R5 no pgood before interval", {pg, aux, flg}, 6'h0);
            ticks(1);
            chk("R5 pgood after interval", {pg, aux, inr}, 3'b110);
            if (c == 0 || c == 1 || c == 5 || c == 7)
               chk("R3 reserved count flags", flg, 4'h0);
            else
               chk("R2 decoded flags", flg, exp_flags(c, s));
            power_down();
            chk("R6 idle after discharge", {dis, cen}, 2'b01);
         end
      end

      // R4 freeze of flags
      power_up(3'd2, 2'b01);
      ticks(1);
      evt = 3'd6; sense = 2'b11;
      ticks(INR - 1);
      chk("R4 flags captured at start", flg, 4'h1);
      evt = 3'd4; sense = 2'b10;
      ticks(2);
      chk("R4 flags unchanged later", flg, 4'h1);

      // R6 collapse
      @(negedge clk);
      uvlo_on = 1'b0; uvlo_off = 1'b1;
      @(negedge clk);
      uvlo_off = 1'b0;
      chk("R6 shutdown outputs", {fet, pg, aux, flg, dis}, 8'h01);
      // R10 turn-on ignored during discharge
      uvlo_on = 1'b1;
      ticks(DIS - 1);
      chk("R10 fet off during discharge", {fet, dis}, 2'b01);
      uvlo_on = 1'b0;
      ticks(1);
      chk("R6 discharge ends", dis, 1'b0);
      power_up(3'd6, 2'b00);
      ticks(INR);
      chk("R6 restart flags", {pg, flg}, 5'h1F);

      // R7 adapter while powered
      @(negedge clk);
      uvlo_on = 1'b0; wa = 1'b1;
      #1;
      chk("R7 override", {fet, pg, aux, cen, flg}, 8'h2F);
      @(negedge clk);
      chk("R7 no discharge", dis, 1'b0);
      uvlo_on = 1'b1;
      repeat (3) @(negedge clk);
      uvlo_on = 1'b0;
      @(negedge clk);
      wa = 1'b0;
      #1;
      chk("R7 no start while adapter", {fet, pg, flg, cen}, 7'h01);

      // R8 pass FET over-temperature
      power_up(3'd3, 2'b11);
      ticks(INR);
      @(negedge clk);
      fot = 1'b1;
      #1;
      chk("R8 fet off at once", {fet, pg}, 2'b00);
      @(negedge clk);
      chk("R8 discharge starts", dis, 1'b1);
      fot = 1'b0;
      uvlo_on = 1'b0;
      ticks(DIS);
      @(negedge clk);
      fot = 1'b1; uvlo_on = 1'b1;
      repeat (2) @(negedge clk);
      chk("R8 no start while hot", {fet, dis}, 2'b00);
      uvlo_on = 1'b0; fot = 1'b0;

      // R9 class sink over-temperature
      @(negedge clk);
      cot = 1'b1;
      #1;
      chk("R9 class off", cen, 1'b0);
      @(negedge clk);
      cot = 1'b0;
      #1;
      chk("R9 class back on", cen, 1'b1);

      // R11 internal prescaler, external tick held high
      repeat (40) @(negedge clk);
      chk("R11 prescaled unit idle", {p_fet, p_dis}, 2'b00);
      uvlo_on = 1'b1;
      begin
         int n;
         n = 0;
         for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            n++;
            if (p_pg) break;
         end
         chk("R11 inrush length in range",
             (n >= (P_INR - 1) * P_CPM + 2 && n <= P_INR * P_CPM + 1), 1'b1);
      end
      power_down();

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule